// File: doc/BRIEF.md
# Miss and Write Buffer Allocation Controller with Blocking Statistics

This block sits between the lookup stage of a cache and its two outstanding-request buffers. One buffer tracks misses and uncacheable reads; the other tracks writes. A caller presents one allocation request per cycle. The request carries a kind, an address, a byte size and a request time. The controller chooses the buffer from the kind and picks the lowest free slot. It shapes the recorded address and size as the kind requires and stamps the entry with a running sequence number. If asked, it also raises a request toward the memory-side bus, labelled with the buffer it came from.

When a buffer fills, the controller sets that buffer's bit in a small blocking mask. An external target-slot exhaustion condition owns a third bit. A single registered stall output toward the CPU side is high whenever any bit is set. The controller counts each transition from unblocked to blocked. It also adds the length of every blocked stretch to a per-cause cycle counter.

Entries leave a buffer through a service input that names the buffer and the slot. A combinational output gives the earliest request time still held in either buffer. An optional limit on cacheable misses produces a one-cycle terminate pulse.

Top module: `missbuf_alloc_ctrl`

## Requirements
- R1: A cacheable miss (kind code 0) goes to buffer 0. Its recorded address is the request address with the low log2(BLK_BYTES) bits cleared, and its recorded size is BLK_BYTES.
- R2: A write (kind code 1) goes to buffer 1, and an uncacheable read (kind code 2) goes to buffer 0. Both keep the exact request address and size. The entry report appears one cycle after the request and names the lowest free slot.
- R3: Every accepted allocation carries the value of a sequence counter that starts at 0 after reset. The counter then rises by one. Rejected requests leave it unchanged.
- R4: If an accepted allocation leaves its buffer full, the buffer's mask bit is set: bit 0 for buffer 0, bit 1 for buffer 1. Bit 2 is set by the target-full-set input and cleared by the target-full-clear input.
- R5: Servicing a slot clears its buffer's mask bit only when the buffer was full before the service and is not full after it. Servicing a buffer that was not full leaves the mask unchanged.
- R6: When a cause is set while the mask is empty, that cause's event counter rises by one and cpu_blocked goes high on the same edge. A cause set while another is already active only joins the mask and counts no event.
- R7: When a clear empties the mask, the number of cycles since the first set is added to the cycle counter of the cleared cause (the lowest cleared index if several clear together), and cpu_blocked falls. A clear that leaves other causes active adds nothing.
- R8: An accepted allocation with its bus flag raises bus_req one cycle later, with cause 0 (buffer 0) or 1 (buffer 1) and the request time. The prefetch input raises cause 2. Allocation takes precedence over prefetch, and no request is raised while retry_wait is high.
- R9: With MISS_LIMIT above 0, the accepted cacheable miss that brings the miss count to MISS_LIMIT produces a single sim_term pulse one cycle later. Later misses produce none. A limit of 0 never pulses.
- R10: A request aimed at a full buffer, or one with kind code 3, is rejected. alloc_err pulses one cycle later and no entry is reported.
- R11: next_ready is the smallest request time among the occupied slots of both buffers, or all ones when both buffers are empty.
- R12: After reset the mask, cpu_blocked, every counter and every pulse output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request present |
| alloc_kind | input | 2 | 0 miss, 1 write, 2 uncacheable read, 3 invalid |
| alloc_addr | input | ADDR_W | Request address |
| alloc_size | input | SIZE_W | Request size in bytes |
| alloc_bus | input | 1 | Also request the memory-side bus |
| req_time | input | TIME_W | Time stamp for allocation and prefetch bus requests |
| pf_req | input | 1 | Prefetch bus request |
| retry_wait | input | 1 | Bus port is waiting on a retry |
| svc_valid | input | 1 | Mark a slot in service |
| svc_queue | input | 1 | Buffer of the serviced slot |
| svc_slot | input | SLOT_W | Serviced slot index |
| tgt_full_set | input | 1 | Set the target-exhaustion cause |
| tgt_full_clr | input | 1 | Clear the target-exhaustion cause |
| ent_valid | output | 1 | Entry report valid |
| ent_kind | output | 2 | Kind of the reported entry |
| ent_queue | output | 1 | Buffer of the reported entry |
| ent_slot | output | SLOT_W | Slot of the reported entry |
| ent_addr | output | ADDR_W | Recorded address |
| ent_size | output | SIZE_W | Recorded size |
| ent_order | output | ORDER_W | Sequence number |
| alloc_err | output | 1 | Rejected request pulse |
| bus_req | output | 1 | Memory-side bus request pulse |
| bus_cause | output | 2 | 0 miss buffer, 1 write buffer, 2 prefetch |
| bus_time | output | TIME_W | Requested time |
| block_mask | output | 3 | Active blocking causes |
| cpu_blocked | output | 1 | Stall toward the CPU side |
| blk_events | output | 3*CNT_W | Per-cause block event counts, cause c at bits c*CNT_W |
| blk_cycles | output | 3*CNT_W | Per-cause blocked-cycle totals, same packing |
| next_ready | output | TIME_W | Earliest held request time |
| sim_term | output | 1 | Miss limit reached pulse |

## Verification
A table of eight requests mixes the three kinds. Addresses are unaligned, already aligned, and at the top of the address space, with sizes from one byte to a full block. This shows whether alignment applies only to cacheable misses and whether the buffer choice follows the kind. Filling each buffer, and then stacking the target cause on a full miss buffer, separates the first-set and last-clear statistics from the plain mask update. Bus requests are tried with and without retry_wait, and with a prefetch in place of an allocation, so each cause code and the suppression are seen.

// File: rtl/missbuf_pkg.sv
package missbuf_pkg;
   typedef enum logic [1:0] {
      KIND_MISS   = 2'd0,
      KIND_WRITE  = 2'd1,
      KIND_UNC_RD = 2'd2,
      KIND_NONE   = 2'd3
   } req_kind_e;

   localparam int NQ        = 2;
   localparam int Q_MISS    = 0;
   localparam int Q_WRITE   = 1;
   localparam int NCAUSE    = 3;
   localparam int CAUSE_TGT = 2;
   localparam logic [1:0] BUS_PF = 2'd2;
endpackage

// File: rtl/missbuf_queue.sv
module missbuf_queue #(
   parameter int DEPTH  = 4,
   parameter int SLOT_W = 2,
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [TIME_W-1:0] alloc_time,
   input  logic              svc_en,
   input  logic [SLOT_W-1:0] svc_slot,
   output logic              full,
   output logic              full_next,
   output logic [SLOT_W-1:0] free_slot,
   output logic [TIME_W-1:0] earliest
);
   if (DEPTH < 1 || DEPTH > (1 << SLOT_W)) begin : g_bad_depth
      $error("missbuf_queue: DEPTH does not fit SLOT_W");
   end

   logic [DEPTH-1:0]  valid_q, valid_d;
   logic [TIME_W-1:0] rtime_q [DEPTH];

   always_comb begin
      logic found;
      found     = 1'b0;
      free_slot = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!valid_q[i] && !found) begin
            free_slot = SLOT_W'(i);
            found     = 1'b1;
         end
      end
   end

   always_comb begin
      valid_d = valid_q;
      for (int i = 0; i < DEPTH; i++) begin
         if (svc_en && svc_slot == SLOT_W'(i)) valid_d[i] = 1'b0;
      end
      for (int i = 0; i < DEPTH; i++) begin
         if (alloc_en && free_slot == SLOT_W'(i)) valid_d[i] = 1'b1;
      end
   end

   assign full      = &valid_q;
   assign full_next = &valid_d;

   always_comb begin
      earliest = '1;
      for (int i = 0; i < DEPTH; i++) begin
         if (valid_q[i] && rtime_q[i] < earliest) earliest = rtime_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         valid_q <= valid_d;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_time
      always_ff @(posedge clk) begin
         if (!rst_n) rtime_q[g] <= '0;
         else if (alloc_en && free_slot == SLOT_W'(g)) rtime_q[g] <= alloc_time;
      end
   end
endmodule

// File: rtl/missbuf_block.sv
module missbuf_block #(
   parameter int NCAUSE = 3,
   parameter int CNT_W  = 16,
   parameter int TIME_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NCAUSE-1:0]        set_vec,
   input  logic [NCAUSE-1:0]        clr_vec,
   output logic [NCAUSE-1:0]        mask,
   output logic                     blocked,
   output logic [NCAUSE*CNT_W-1:0]  events,
   output logic [NCAUSE*CNT_W-1:0]  cycles
);
   localparam int IDX_W = (NCAUSE > 1) ? $clog2(NCAUSE) : 1;

   logic [NCAUSE-1:0] mask_d;
   logic [TIME_W-1:0] now_q, start_q, elapsed;
   logic              first_set, last_clr;
   logic [IDX_W-1:0]  clr_idx;

   assign mask_d    = (mask | set_vec) & ~clr_vec;
   assign first_set = (mask == '0) && (set_vec != '0);
   assign last_clr  = (mask != '0) && (mask_d == '0);
   assign elapsed   = now_q - start_q;

   always_comb begin
      logic found;
      found   = 1'b0;
      clr_idx = '0;
      for (int i = 0; i < NCAUSE; i++) begin
         if (clr_vec[i] && mask[i] && !found) begin
            clr_idx = IDX_W'(i);
            found   = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask    <= '0;
         blocked <= 1'b0;
         now_q   <= '0;
         start_q <= '0;
      end else begin
         mask    <= mask_d;
         blocked <= (mask_d != '0);
         now_q   <= now_q + 1'b1;
         if (first_set) start_q <= now_q;
      end
   end

   for (genvar c = 0; c < NCAUSE; c++) begin : g_cause
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            events[c*CNT_W +: CNT_W] <= '0;
            cycles[c*CNT_W +: CNT_W] <= '0;
         end else begin
            if (first_set && set_vec[c])
               events[c*CNT_W +: CNT_W] <= events[c*CNT_W +: CNT_W] + 1'b1;
            if (last_clr && clr_idx == IDX_W'(c))
               cycles[c*CNT_W +: CNT_W] <= cycles[c*CNT_W +: CNT_W] + CNT_W'(elapsed);
         end
      end
   end
endmodule

// File: rtl/missbuf_alloc_ctrl.sv
module missbuf_alloc_ctrl
   import missbuf_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SIZE_W     = 8,
   parameter int TIME_W     = 32,
   parameter int ORDER_W    = 16,
   parameter int CNT_W      = 16,
   parameter int BLK_BYTES  = 64,
   parameter int MQ_DEPTH   = 4,
   parameter int WB_DEPTH   = 4,
   parameter int MISS_LIMIT = 0,
   localparam int SLOT_W    = $clog2((MQ_DEPTH > WB_DEPTH ? MQ_DEPTH : WB_DEPTH) + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      alloc_valid,
   input  logic [1:0]                alloc_kind,
   input  logic [ADDR_W-1:0]         alloc_addr,
   input  logic [SIZE_W-1:0]         alloc_size,
   input  logic                      alloc_bus,
   input  logic [TIME_W-1:0]         req_time,
   input  logic                      pf_req,
   input  logic                      retry_wait,
   input  logic                      svc_valid,
   input  logic                      svc_queue,
   input  logic [SLOT_W-1:0]         svc_slot,
   input  logic                      tgt_full_set,
   input  logic                      tgt_full_clr,
   output logic                      ent_valid,
   output logic [1:0]                ent_kind,
   output logic                      ent_queue,
   output logic [SLOT_W-1:0]         ent_slot,
   output logic [ADDR_W-1:0]         ent_addr,
   output logic [SIZE_W-1:0]         ent_size,
   output logic [ORDER_W-1:0]        ent_order,
   output logic                      alloc_err,
   output logic                      bus_req,
   output logic [1:0]                bus_cause,
   output logic [TIME_W-1:0]         bus_time,
   output logic [NCAUSE-1:0]         block_mask,
   output logic                      cpu_blocked,
   output logic [NCAUSE*CNT_W-1:0]   blk_events,
   output logic [NCAUSE*CNT_W-1:0]   blk_cycles,
   output logic [TIME_W-1:0]         next_ready,
   output logic                      sim_term
);
   if ((BLK_BYTES & (BLK_BYTES - 1)) != 0 || BLK_BYTES >= (1 << SIZE_W)) begin : g_bad_blk
      $error("missbuf_alloc_ctrl: BLK_BYTES must be a power of two below 2**SIZE_W");
   end
   if (MQ_DEPTH < 1 || WB_DEPTH < 1) begin : g_bad_depth
      $error("missbuf_alloc_ctrl: buffer depths must be positive");
   end

   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(BLK_BYTES) - 1'b1);

   req_kind_e           kind;
   logic                tq, accept;
   logic [NQ-1:0]       q_alloc, q_svc, q_full, q_full_nx;
   logic [SLOT_W-1:0]   q_slot  [NQ];
   logic [TIME_W-1:0]   q_early [NQ];
   logic [ORDER_W-1:0]  order_q;
   logic [NCAUSE-1:0]   set_vec, clr_vec;

   assign kind   = req_kind_e'(alloc_kind);
   assign tq     = (kind == KIND_WRITE);
   assign accept = alloc_valid && (kind != KIND_NONE) && !q_full[tq];

   for (genvar q = 0; q < NQ; q++) begin : g_q
      assign q_alloc[q] = accept && (tq == q[0]);
      assign q_svc[q]   = svc_valid && (svc_queue == q[0]);
      missbuf_queue #(
         .DEPTH  (q == Q_MISS ? MQ_DEPTH : WB_DEPTH),
         .SLOT_W (SLOT_W),
         .TIME_W (TIME_W)
      ) u_q (
         .clk        (clk),
         .rst_n      (rst_n),
         .alloc_en   (q_alloc[q]),
         .alloc_time (req_time),
         .svc_en     (q_svc[q]),
         .svc_slot   (svc_slot),
         .full       (q_full[q]),
         .full_next  (q_full_nx[q]),
         .free_slot  (q_slot[q]),
         .earliest   (q_early[q])
      );
      assign set_vec[q] = q_alloc[q] && q_full_nx[q];
      assign clr_vec[q] = q_svc[q] && q_full[q] && !q_full_nx[q];
   end
   assign set_vec[CAUSE_TGT] = tgt_full_set;
   assign clr_vec[CAUSE_TGT] = tgt_full_clr;

   assign next_ready = (q_early[Q_MISS] < q_early[Q_WRITE]) ? q_early[Q_MISS] : q_early[Q_WRITE];

   missbuf_block #(.NCAUSE(NCAUSE), .CNT_W(CNT_W), .TIME_W(TIME_W)) u_blk (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .mask    (block_mask),
      .blocked (cpu_blocked),
      .events  (blk_events),
      .cycles  (blk_cycles)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_valid <= 1'b0;
         ent_kind  <= '0;
         ent_queue <= 1'b0;
         ent_slot  <= '0;
         ent_addr  <= '0;
         ent_size  <= '0;
         ent_order <= '0;
         order_q   <= '0;
         alloc_err <= 1'b0;
         bus_req   <= 1'b0;
         bus_cause <= '0;
         bus_time  <= '0;
      end else begin
         ent_valid <= accept;
         alloc_err <= alloc_valid && !accept;
         if (accept) begin
            ent_kind  <= alloc_kind;
            ent_queue <= tq;
            ent_slot  <= q_slot[tq];
            ent_order <= order_q;
            order_q   <= order_q + 1'b1;
            if (kind == KIND_MISS) begin
               ent_addr <= alloc_addr & ALIGN_MASK;
               ent_size <= SIZE_W'(BLK_BYTES);
            end else begin
               ent_addr <= alloc_addr;
               ent_size <= alloc_size;
            end
         end
         bus_req <= 1'b0;
         if (!retry_wait) begin
            if (accept && alloc_bus) begin
               bus_req   <= 1'b1;
               bus_cause <= {1'b0, tq};
               bus_time  <= req_time;
            end else if (pf_req) begin
               bus_req   <= 1'b1;
               bus_cause <= BUS_PF;
               bus_time  <= req_time;
            end
         end
      end
   end

   if (MISS_LIMIT > 0) begin : g_limit
      localparam int LIM_W = $clog2(MISS_LIMIT + 1);
      logic [LIM_W-1:0] misses_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            misses_q <= '0;
            sim_term <= 1'b0;
         end else begin
            sim_term <= 1'b0;
            if (accept && kind == KIND_MISS && misses_q != LIM_W'(MISS_LIMIT)) begin
               misses_q <= misses_q + 1'b1;
               sim_term <= (misses_q == LIM_W'(MISS_LIMIT - 1));
            end
         end
      end
   end else begin : g_nolimit
      assign sim_term = 1'b0;
   end
endmodule

// File: rtl/missbuf_chk.sv
module missbuf_chk #(
   parameter int ADDR_W    = 32,
   parameter int SIZE_W    = 8,
   parameter int ORDER_W   = 16,
   parameter int CNT_W     = 16,
   parameter int BLK_BYTES = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ent_valid,
   input logic [1:0]         ent_kind,
   input logic               ent_queue,
   input logic [ADDR_W-1:0]  ent_addr,
   input logic [SIZE_W-1:0]  ent_size,
   input logic [ORDER_W-1:0] ent_order,
   input logic               alloc_err,
   input logic               bus_req,
   input logic [1:0]         bus_cause,
   input logic               cpu_blocked,
   input logic [3*CNT_W-1:0] blk_events,
   input logic [3*CNT_W-1:0] blk_cycles
);
   logic [ORDER_W-1:0] seen_q;
   logic [CNT_W+1:0]   ev_total, cy_total;

   assign ev_total = (CNT_W+2)'(blk_events[0 +: CNT_W]) + (CNT_W+2)'(blk_events[CNT_W +: CNT_W])
                   + (CNT_W+2)'(blk_events[2*CNT_W +: CNT_W]);
   assign cy_total = (CNT_W+2)'(blk_cycles[0 +: CNT_W]) + (CNT_W+2)'(blk_cycles[CNT_W +: CNT_W])
                   + (CNT_W+2)'(blk_cycles[2*CNT_W +: CNT_W]);

   always_ff @(posedge clk) begin
      if (!rst_n) seen_q <= '0;
      else if (ent_valid) seen_q <= seen_q + 1'b1;
   end

   // R1
   miss_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_valid && ent_kind == 2'd0) |->
         ((ent_addr & ADDR_W'(BLK_BYTES - 1)) == '0 && ent_size == SIZE_W'(BLK_BYTES)));

   // R3
   order_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid |-> ent_order == seen_q);

   // R6
   block_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_blocked) |-> ev_total == $past(ev_total) + 1'b1);

   // R7
   block_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_blocked) |-> cy_total > $past(cy_total));

   // R8
   bus_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_cause != 2'd2) |-> (ent_valid && bus_cause == {1'b0, ent_queue}));

   // R10
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_err |-> !ent_valid);
endmodule

bind missbuf_alloc_ctrl missbuf_chk #(
   .ADDR_W    (ADDR_W),
   .SIZE_W    (SIZE_W),
   .ORDER_W   (ORDER_W),
   .CNT_W     (CNT_W),
   .BLK_BYTES (BLK_BYTES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ent_valid   (ent_valid),
   .ent_kind    (ent_kind),
   .ent_queue   (ent_queue),
   .ent_addr    (ent_addr),
   .ent_size    (ent_size),
   .ent_order   (ent_order),
   .alloc_err   (alloc_err),
   .bus_req     (bus_req),
   .bus_cause   (bus_cause),
   .cpu_blocked (cpu_blocked),
   .blk_events  (blk_events),
   .blk_cycles  (blk_cycles)
);

// File: tb/sim_missbuf_alloc_ctrl.sv
`timescale 1ns/1ps
module sim_missbuf_alloc_ctrl;
   localparam int ADDR_W = 32, SIZE_W = 8, TIME_W = 32, ORDER_W = 16, CNT_W = 16;
   localparam int BLK = 64, DEPTH = 4, LIMIT = 6, SLOT_W = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic alloc_valid = 0, alloc_bus = 0, pf_req = 0, retry_wait = 0;
   logic svc_valid = 0, svc_queue = 0, tgt_full_set = 0, tgt_full_clr = 0;
   logic [1:0] alloc_kind = 0;
   logic [ADDR_W-1:0] alloc_addr = 0;
   logic [SIZE_W-1:0] alloc_size = 0;
   logic [TIME_W-1:0] req_time = 0;
   logic [SLOT_W-1:0] svc_slot = 0;
   logic ent_valid, ent_queue, alloc_err, bus_req, cpu_blocked, sim_term;
   logic [1:0] ent_kind, bus_cause;
   logic [SLOT_W-1:0] ent_slot;
   logic [ADDR_W-1:0] ent_addr;
   logic [SIZE_W-1:0] ent_size;
   logic [ORDER_W-1:0] ent_order;
   logic [TIME_W-1:0] bus_time, next_ready;
   logic [2:0] block_mask;
   logic [3*CNT_W-1:0] blk_events, blk_cycles;

   always #2.5 clk = ~clk;

   missbuf_alloc_ctrl #(.MISS_LIMIT(LIMIT)) u0 (.*);

   int checks = 0, errors = 0;
   logic done = 1'b0;
   logic [DEPTH-1:0] qv [2];
   int order = 0, misses = 0;

   // kind, addr, size, expected addr, expected size
   localparam logic [81:0] TBL [8] = '{
      {2'd0, 32'h0000_1234, 8'd4,  32'h0000_1200, 8'd64},
      {2'd1, 32'h0000_1234, 8'd4,  32'h0000_1234, 8'd4},
      {2'd2, 32'h0000_2003, 8'd1,  32'h0000_2003, 8'd1},
      {2'd0, 32'h0000_00FF, 8'd8,  32'h0000_00C0, 8'd64},
      {2'd0, 32'hFFFF_FFFF, 8'd1,  32'hFFFF_FFC0, 8'd64},
      {2'd1, 32'h0000_0041, 8'd64, 32'h0000_0041, 8'd64},
      {2'd2, 32'h8000_0040, 8'd8,  32'h8000_0040, 8'd8},
      {2'd0, 32'h8000_0040, 8'd2,  32'h8000_0040, 8'd64}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [CNT_W-1:0] ev(input int c);
      return blk_events[c*CNT_W +: CNT_W];
   endfunction
   function automatic logic [CNT_W-1:0] cy(input int c);
      return blk_cycles[c*CNT_W +: CNT_W];
   endfunction

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Drives one request for one cycle and checks the entry report at the next negedge.
   task automatic do_alloc(input logic [1:0] k, input logic [31:0] a, input logic [7:0] s,
                           input logic [31:0] ea, input logic [7:0] es,
                           input logic bus, input logic rw, input logic [31:0] t);
      int q, slot;
      logic acc;
      q = (k == 2'd1) ? 1 : 0;
      acc = (k != 2'd3) && !(&qv[q]);
      slot = 0;
      for (int i = DEPTH - 1; i >= 0; i--) if (!qv[q][i]) slot = i;
      alloc_valid = 1; alloc_kind = k; alloc_addr = a; alloc_size = s;
      alloc_bus = bus; retry_wait = rw; req_time = t;
      @(negedge clk);
      alloc_valid = 0; alloc_bus = 0; retry_wait = 0;
      chk("R10 accept", {ent_valid, alloc_err}, {acc, !acc});
      // R9: terminate pulse only on the miss that reaches the limit
      chk("R9 term", sim_term, acc && k == 2'd0 && misses + 1 == LIMIT);
      if (acc) begin
         chk("R1/R2 queue", ent_queue, q);
         chk("R2 slot", ent_slot, slot);
         chk("R1/R2 addr", ent_addr, ea);
         chk("R1/R2 size", ent_size, es);
         chk("R3 order", ent_order, order);
         qv[q][slot] = 1'b1;
         order++;
         if (k == 2'd0) misses++;
      end
   endtask

   task automatic do_svc(input int q, input int slot);
      svc_valid = 1; svc_queue = q[0]; svc_slot = SLOT_W'(slot);
      @(negedge clk);
      svc_valid = 0;
      qv[q][slot] = 1'b0;
   endtask

   task automatic pulse_tgt(input logic set);
      tgt_full_set = set; tgt_full_clr = !set;
      @(negedge clk);
      tgt_full_set = 0; tgt_full_clr = 0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      qv[0] = '0; qv[1] = '0;
      idle(3);
      rst_n = 1;
      idle(1);
      // R12 reset state
      chk("R12 reset pulses", {ent_valid, alloc_err, bus_req, sim_term, cpu_blocked}, 0);
      chk("R12 reset mask", block_mask, 0);
      chk("R12 reset counters", {blk_events, blk_cycles}, 0);
      chk("R11 empty next_ready", next_ready, 32'hFFFF_FFFF);

      // Table walk: each entry is allocated then serviced again.
      for (int i = 0; i < 8; i++) begin
         do_alloc(TBL[i][81:80], TBL[i][79:48], TBL[i][47:40], TBL[i][39:8], TBL[i][7:0],
                  0, 0, 32'd10 + i);
         do_svc((TBL[i][81:80] == 2'd1) ? 1 : 0, 0);
      end
      chk("R5 no block from table", block_mask, 0);

      // Fill the miss buffer.
      for (int i = 0; i < DEPTH; i++)
         do_alloc(2'd0, 32'h100 * i + 5, 8'd1, 32'h100 * i, 8'd64, 0, 0, 32'd100 + i);
      chk("R4 miss full mask", block_mask, 3'b001);
      chk("R6 blocked", cpu_blocked, 1);
      chk("R6 event miss", ev(0), 1);
      chk("R11 earliest", next_ready, 100);
      idle(5);
      do_alloc(2'd0, 32'h40, 8'd1, 0, 0, 0, 0, 32'd99);
      chk("R10 order kept", order, 12);
      pulse_tgt(1);
      chk("R6 join mask", block_mask, 3'b101);
      chk("R6 no event for join", ev(2), 0);
      do_svc(0, 0);
      chk("R5 full to not full clears", block_mask, 3'b100);
      chk("R7 still blocked", cpu_blocked, 1);
      chk("R7 no cycles while active", cy(0), 0);
      chk("R11 after service", next_ready, 101);
      do_svc(0, 1);
      chk("R5 not-full service keeps mask", block_mask, 3'b100);
      idle(2);
      pulse_tgt(0);
      chk("R7 last clear unblocks", {cpu_blocked, block_mask}, 0);
      chk("R7 cycles to target cause", cy(2), 12);
      chk("R7 other causes untouched", {cy(1), cy(0)}, 0);
      do_svc(0, 2);
      do_svc(0, 3);
      chk("R11 empty again", next_ready, 32'hFFFF_FFFF);

      // Bus requests and the write buffer.
      do_alloc(2'd1, 32'h300, 8'd4, 32'h300, 8'd4, 1, 0, 32'd200);
      chk("R8 write bus req", {bus_req, bus_cause, bus_time}, {1'b1, 2'd1, 32'd200});
      do_alloc(2'd1, 32'h304, 8'd4, 32'h304, 8'd4, 1, 1, 32'd201);
      chk("R8 retry suppresses", bus_req, 0);
      do_alloc(2'd0, 32'h47F, 8'd4, 32'h440, 8'd64, 1, 0, 32'd202);
      chk("R8 miss bus req", {bus_req, bus_cause, bus_time}, {1'b1, 2'd0, 32'd202});
      pf_req = 1; req_time = 300;
      @(negedge clk);
      pf_req = 0;
      chk("R8 prefetch cause", {bus_req, bus_cause, bus_time}, {1'b1, 2'd2, 32'd300});
      pf_req = 1; retry_wait = 1;
      @(negedge clk);
      pf_req = 0; retry_wait = 0;
      chk("R8 prefetch suppressed", bus_req, 0);
      do_alloc(2'd1, 32'h308, 8'd2, 32'h308, 8'd2, 0, 0, 32'd203);
      do_alloc(2'd1, 32'h30A, 8'd2, 32'h30A, 8'd2, 0, 0, 32'd204);
      chk("R4 write full mask", block_mask, 3'b010);
      chk("R6 event write", ev(1), 1);
      do_alloc(2'd1, 32'h30C, 8'd2, 0, 0, 0, 0, 32'd205);
      do_alloc(2'd3, 32'h0, 8'd1, 0, 0, 0, 0, 32'd206);
      do_svc(1, 0);
      chk("R7 write cycles", cy(1), 3);
      chk("R7 unblocked", cpu_blocked, 0);
      chk("R6 events total", {ev(2), ev(1), ev(0)}, {16'd0, 16'd1, 16'd1});
      chk("R3 final order", order, 17);
      done = 1'b1;
      finish_run();
   end
endmodule